// File: doc/BRIEF.md
# Zero-turnaround late-write synchronous SRAM

This block is a synthesizable model of a small synchronous static RAM whose data bus never needs an idle cycle between a read and a write. Every command (address, chip selects, read/write select, burst-advance, byte write enables) is captured on the rising clock edge. Write data comes later than its address, so the bus slot the write leaves empty can carry read data from an earlier command. A static timing input picks one of two latencies. In flow-through timing, read data appears one edge after the address and write data is taken one edge after the address. In pipelined timing, read data passes through an output register and write data is taken two edges after the address.

The array is organised as byte lanes of nine bits. A static order input picks how a four-beat burst walks the two low address bits. Output enable and sleep act on the output drive without waiting for a clock. The pad is modelled as a data bus plus a drive flag. The bus runs at a fixed latency with no back-pressure: one command may be issued every cycle and is never stalled. A read that hits an address whose late write is still in flight returns the newer bytes.

Top module: `nbt_sram`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `rdata_drive` is 0.
- R2: With `mode_pipe`=0, a read captured at edge k drives `rdata` with the word at its address between edge k and edge k+1, with `rdata_drive`=1.
- R3: With `mode_pipe`=1, a read captured at edge k is driven between edge k+1 and edge k+2.
- R4: A write captured at edge k takes its data from `wdata` at edge k+1 when `mode_pipe`=0 and at edge k+2 when `mode_pipe`=1. `wdata` at any other edge has no effect.
- R5: Reads and writes in any order may be issued on consecutive edges, and each read returns every byte written by all earlier commands.
- R6: With `burst_xor`=0, each `adv`=1 cycle continues the open burst at low address bits (start + n) mod 4, where n is the beat number (1, 2, 3, 0, ...), and leaves the upper bits unchanged.
- R7: With `burst_xor`=1, burst beat n uses low address bits (start XOR n).
- R8: `byte_we[i]`=1 writes bits [9i+8:9i]. A lane whose enable is 0 keeps its old value.
- R9: A cycle is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0 with `adv`=0. Any other non-advance cycle writes nothing, drives nothing and closes the open burst.
- R10: `oe`=0 turns `rdata_drive` off at once, even while a read is being driven.
- R11: `adv`=1 ignores `addr`, the chip selects and `wr_sel`, and reuses the read/write type of the burst's first command. With no open burst it is a no-operation.
- R12: With `mode_pipe`=1, a read issued on the edge right after a write to the same address returns that write's data in the enabled lanes and the stored data in the others.
- R13: `sleep`=1 turns the drive off at once and makes captured cycles no-operations that close the burst. Writes already captured still complete, and the stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| mode_pipe | input | 1 | 1 = pipelined timing, 0 = flow-through timing (static) |
| burst_xor | input | 1 | 1 = XOR burst order, 0 = linear burst order (static) |
| addr | input | ADDR_W | Word address |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| wr_sel | input | 1 | 1 = write, 0 = read |
| adv | input | 1 | Continue the open burst |
| byte_we | input | N_BYTES | Per-lane write enables, active high |
| wdata | input | DATA_W | Late write data |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep request, active high |
| rdata | output | DATA_W | Read data |
| rdata_drive | output | 1 | 1 when `rdata` would be driven onto the bus |

## Verification
The hardest case to reach from the ports is a pipelined read that arrives one edge after a partial-lane write to the same word. The write data is then only on the `wdata` pins and not yet in the array. The random stimulus keeps most addresses inside a sixteen-word window and mixes reads, writes and advances freely, so these collisions happen often. Directed sequences add alternating write/read pairs and a sleep request raised while a pipelined write still waits for its data.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  // a burst always spans four beats; the low two address bits walk it
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;

  function automatic logic [BEAT_W-1:0] beat_low(
    input logic [BEAT_W-1:0] start_low,
    input logic [BEAT_W-1:0] beat,
    input burst_order_e      order
  );
    if (order == ORDER_XOR) return start_low ^ beat;
    return start_low + beat;
  endfunction
endpackage

// File: rtl/nbt_burst_gen.sv
module nbt_burst_gen import nbt_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              adv,
  input  logic              sel,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] addr,
  input  burst_order_e      order,
  output logic              cmd_vld,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic              open_q;
  logic              type_wr_q;
  logic [ADDR_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_nxt;

  assign beat_nxt = beat_q + 1'b1;

  always_comb begin
    cmd_vld  = 1'b0;
    cmd_wr   = 1'b0;
    cmd_addr = addr;
    if (!sleep) begin
      if (adv) begin
        cmd_vld  = open_q;
        cmd_wr   = type_wr_q;
        cmd_addr = {start_q[ADDR_W-1:BEAT_W],
                    beat_low(start_q[BEAT_W-1:0], beat_nxt, order)};
      end else if (sel) begin
        cmd_vld = 1'b1;
        cmd_wr  = wr_sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      type_wr_q <= 1'b0;
      start_q   <= '0;
      beat_q    <= '0;
    end else if (sleep) begin
      open_q <= 1'b0;
    end else if (adv) begin
      if (open_q) beat_q <= beat_nxt;
    end else if (sel) begin
      open_q    <= 1'b1;
      type_wr_q <= wr_sel;
      start_q   <= addr;
      beat_q    <= '0;
    end else begin
      open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nbt_cmd_pipe.sv
module nbt_cmd_pipe #(
  parameter int ADDR_W  = 8,
  parameter int N_BYTES = 2,
  parameter int DEPTH   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic               in_wr,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [N_BYTES-1:0] in_be,
  output logic               st_vld  [DEPTH],
  output logic               st_wr   [DEPTH],
  output logic [ADDR_W-1:0]  st_addr [DEPTH],
  output logic [N_BYTES-1:0] st_be   [DEPTH]
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic               src_vld;
    logic               src_wr;
    logic [ADDR_W-1:0]  src_addr;
    logic [N_BYTES-1:0] src_be;
    if (s == 0) begin : g_head
      assign src_vld  = in_vld;
      assign src_wr   = in_wr;
      assign src_addr = in_addr;
      assign src_be   = in_be;
    end else begin : g_tail
      assign src_vld  = st_vld[s-1];
      assign src_wr   = st_wr[s-1];
      assign src_addr = st_addr[s-1];
      assign src_be   = st_be[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_vld[s]  <= 1'b0;
        st_wr[s]   <= 1'b0;
        st_addr[s] <= '0;
        st_be[s]   <= '0;
      end else begin
        st_vld[s]  <= src_vld;
        st_wr[s]   <= src_wr;
        st_addr[s] <= src_addr;
        st_be[s]   <= src_be;
      end
    end
  end
endmodule

// File: rtl/nbt_store.sv
module nbt_store #(
  parameter int ADDR_W  = 8,
  parameter int BYTE_W  = 9,
  parameter int N_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [N_BYTES-1:0]        wr_be,
  input  logic [BYTE_W*N_BYTES-1:0] wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic                      fwd_en,
  output logic [BYTE_W*N_BYTES-1:0] rd_data
);
  localparam int WORDS = 1 << ADDR_W;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] cells [WORDS];
    logic [BYTE_W-1:0] lane_in;
    logic              lane_we;

    assign lane_in = wr_data[b*BYTE_W +: BYTE_W];
    assign lane_we = wr_en && wr_be[b];

    always_ff @(posedge clk) begin
      if (lane_we) cells[wr_addr] <= lane_in;
    end

    // a lane still waiting for its late data is taken from the bus
    assign rd_data[b*BYTE_W +: BYTE_W] = (fwd_en && lane_we) ? lane_in : cells[rd_addr];
  end
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram import nbt_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int BYTE_W  = 9,
  parameter int N_BYTES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_pipe,
  input  logic                      burst_xor,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      cs0_n,
  input  logic                      cs1,
  input  logic                      cs2_n,
  input  logic                      wr_sel,
  input  logic                      adv,
  input  logic [N_BYTES-1:0]        byte_we,
  input  logic [BYTE_W*N_BYTES-1:0] wdata,
  input  logic                      oe,
  input  logic                      sleep,
  output logic [BYTE_W*N_BYTES-1:0] rdata,
  output logic                      rdata_drive
);
  localparam int DATA_W  = BYTE_W * N_BYTES;
  localparam int N_STAGE = 2;

  logic              sel_all;
  logic              cmd_vld;
  logic              cmd_wr;
  logic [ADDR_W-1:0] cmd_addr;

  logic               st_vld  [N_STAGE];
  logic               st_wr   [N_STAGE];
  logic [ADDR_W-1:0]  st_addr [N_STAGE];
  logic [N_BYTES-1:0] st_be   [N_STAGE];

  logic               com_en;
  logic [ADDR_W-1:0]  com_addr;
  logic [N_BYTES-1:0] com_be;
  logic               fwd_hit;
  logic               rd_now;
  logic [DATA_W-1:0]  rd_word;
  logic               oreg_vld;
  logic [DATA_W-1:0]  oreg_data;
  logic               out_vld;

  assign sel_all = ~cs0_n & cs1 & ~cs2_n;

  nbt_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .adv      (adv),
    .sel      (sel_all),
    .wr_sel   (wr_sel),
    .addr     (addr),
    .order    (burst_order_e'(burst_xor)),
    .cmd_vld  (cmd_vld),
    .cmd_wr   (cmd_wr),
    .cmd_addr (cmd_addr)
  );

  nbt_cmd_pipe #(.ADDR_W(ADDR_W), .N_BYTES(N_BYTES), .DEPTH(N_STAGE)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (cmd_vld),
    .in_wr   (cmd_wr),
    .in_addr (cmd_addr),
    .in_be   (byte_we),
    .st_vld  (st_vld),
    .st_wr   (st_wr),
    .st_addr (st_addr),
    .st_be   (st_be)
  );

  // the timing mode picks which stage meets its late data on the bus
  always_comb begin
    if (mode_pipe) begin
      com_en   = st_vld[1] && st_wr[1];
      com_addr = st_addr[1];
      com_be   = st_be[1];
    end else begin
      com_en   = st_vld[0] && st_wr[0];
      com_addr = st_addr[0];
      com_be   = st_be[0];
    end
  end

  assign rd_now  = st_vld[0] && !st_wr[0];
  assign fwd_hit = mode_pipe && com_en && (com_addr == st_addr[0]);

  nbt_store #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_store (
    .clk     (clk),
    .wr_en   (com_en),
    .wr_addr (com_addr),
    .wr_be   (com_be),
    .wr_data (wdata),
    .rd_addr (st_addr[0]),
    .fwd_en  (fwd_hit),
    .rd_data (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oreg_vld  <= 1'b0;
      oreg_data <= '0;
    end else begin
      oreg_vld <= rd_now;
      if (rd_now) oreg_data <= rd_word;
    end
  end

  assign out_vld     = mode_pipe ? oreg_vld : rd_now;
  assign rdata       = mode_pipe ? oreg_data : rd_word;
  assign rdata_drive = out_vld && oe && !sleep;
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_pipe,
  input logic cs0_n,
  input logic cs1,
  input logic cs2_n,
  input logic wr_sel,
  input logic adv,
  input logic oe,
  input logic sleep,
  input logic rdata_drive
);
  logic sel_all;
  assign sel_all = ~cs0_n & cs1 & ~cs2_n;

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !rdata_drive);

  a_r10_oe_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !rdata_drive);

  a_r13_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_drive);

  a_r2_ft_read_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pipe && rdata_drive) |->
      ($past(!sleep) && ($past(adv) || ($past(sel_all) && !$past(wr_sel)))));

  a_r3_pipe_read_source: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_pipe && rdata_drive) |->
      ($past(!sleep, 2) && ($past(adv, 2) || ($past(sel_all, 2) && !$past(wr_sel, 2)))));

  a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pipe && !$past(sel_all) && !$past(adv)) |-> !rdata_drive);
endmodule

bind nbt_sram nbt_sram_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_pipe   (mode_pipe),
  .cs0_n       (cs0_n),
  .cs1         (cs1),
  .cs2_n       (cs2_n),
  .wr_sel      (wr_sel),
  .adv         (adv),
  .oe          (oe),
  .sleep       (sleep),
  .rdata_drive (rdata_drive)
);

// File: tb/nbt_sram_bench.sv
module nbt_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int W  = BW * NB;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_pipe = 1'b0;
  logic          burst_xor = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs0_n = 1'b1;
  logic          cs1 = 1'b0;
  logic          cs2_n = 1'b1;
  logic          wr_sel = 1'b0;
  logic          adv = 1'b0;
  logic [NB-1:0] byte_we = '0;
  logic [W-1:0]  wdata = '0;
  logic          oe = 1'b1;
  logic          sleep = 1'b0;
  logic [W-1:0]  rdata;
  logic          rdata_drive;

  always #(CLK_PERIOD/2) clk = ~clk;

  nbt_sram u_nbt_sram (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .burst_xor(burst_xor),
    .addr(addr), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .wr_sel(wr_sel),
    .adv(adv), .byte_we(byte_we), .wdata(wdata), .oe(oe), .sleep(sleep),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [W-1:0] ref_mem [WORDS];
  bit           slot_rd [8];
  logic [W-1:0] slot_rd_data [8];
  string        slot_tag [8];
  bit           slot_wr [8];
  logic [W-1:0] slot_wr_data [8];
  int           cyc = 0;
  bit           m_pipe = 0;
  bit           m_xor = 0;
  bit           b_open = 0;
  bit           b_wr = 0;
  logic [AW-1:0] b_start = '0;
  logic [1:0]   b_beat = '0;
  bit           prev_w = 0;
  logic [AW-1:0] prev_wa = '0;
  string        cur_tag = "";
  bit           oe_probe = 0;

  function automatic logic [W-1:0] merge_word(logic [W-1:0] old_w, logic [W-1:0] new_w,
                                              logic [NB-1:0] be);
    logic [W-1:0] r = old_w;
    for (int b = 0; b < NB; b++)
      if (be[b]) r[b*BW +: BW] = new_w[b*BW +: BW];
    return r;
  endfunction

  function automatic logic [1:0] model_low(logic [1:0] s, logic [1:0] n, bit x);
    return x ? (s ^ n) : (s + n);
  endfunction

  task automatic check(bit ok, string tag, logic [W:0] act, logic [W:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(bit s_all, bit w, bit a, logic [AW-1:0] ad, logic [NB-1:0] be,
                      logic [W-1:0] wd);
    int lat = m_pipe ? 1 : 0;
    int si;
    bit op_v = 0;
    bit op_w = 0;
    logic [AW-1:0] op_a = '0;
    bit exp_drv;
    string tg;
    int r;
    if (s_all) begin
      cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
    end else begin
      r = $urandom_range(1, 7);
      cs0_n = r[0]; cs1 = !r[1]; cs2_n = r[2];
    end
    wr_sel = w; adv = a; addr = ad; byte_we = be;
    si = cyc % 8;
    wdata = slot_wr[si] ? slot_wr_data[si] : W'($urandom);
    slot_wr[si] = 0;
    if (sleep) b_open = 0;
    else if (a) begin
      if (b_open) begin
        b_beat = b_beat + 2'd1;
        op_v = 1; op_w = b_wr;
        op_a = {b_start[AW-1:2], model_low(b_start[1:0], b_beat, m_xor)};
      end
    end else if (s_all) begin
      b_open = 1; b_wr = w; b_start = ad; b_beat = '0;
      op_v = 1; op_w = w; op_a = ad;
    end else b_open = 0;
    if (op_v && op_w) begin
      ref_mem[op_a] = merge_word(ref_mem[op_a], wd, be);
      si = (cyc + 1 + lat) % 8;
      slot_wr[si] = 1; slot_wr_data[si] = wd;
    end
    if (op_v && !op_w) begin
      si = (cyc + lat) % 8;
      slot_rd[si] = 1; slot_rd_data[si] = ref_mem[op_a];
      if (cur_tag != "") tg = cur_tag;
      else if (m_pipe && prev_w && prev_wa == op_a) tg = "R12";
      else if (a) tg = m_xor ? "R7" : "R6";
      else tg = m_pipe ? "R3" : "R2";
      slot_tag[si] = tg;
    end
    prev_w = op_v && op_w; prev_wa = op_a;
    @(posedge clk);
    #(CLK_PERIOD/4);
    si = cyc % 8;
    exp_drv = slot_rd[si] && oe && !sleep;
    tg = slot_rd[si] ? slot_tag[si] : (cur_tag != "" ? cur_tag : "R9");
    check(rdata_drive == exp_drv, tg, {{W{1'b0}}, rdata_drive}, {{W{1'b0}}, exp_drv});
    if (exp_drv) check(rdata == slot_rd_data[si], tg, {1'b0, rdata}, {1'b0, slot_rd_data[si]});
    if (oe_probe && exp_drv) begin
      oe = 1'b0;
      #1;
      check(!rdata_drive, "R10", {{W{1'b0}}, rdata_drive}, '0);
      oe = 1'b1;
    end
    slot_rd[si] = 0;
    cyc++;
  endtask

  task automatic nop();
    step(0, 0, 0, AW'($urandom), '0, '0);
  endtask

  task automatic reset_dut(bit p, bit x);
    rst_n = 1'b0;
    mode_pipe = p; burst_xor = x; m_pipe = p; m_xor = x;
    cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1; adv = 1'b0; oe = 1'b1; sleep = 1'b0;
    for (int i = 0; i < 8; i++) begin slot_rd[i] = 0; slot_wr[i] = 0; end
    b_open = 0; prev_w = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check(!rdata_drive, "R1", {{W{1'b0}}, rdata_drive}, '0);
    rst_n = 1'b1;
  endtask

  task automatic directed();
    logic [W-1:0] d;
    cur_tag = "R5";
    for (int i = 0; i < 6; i++) begin
      step(1, 1, 0, AW'(20 + i), 2'b11, W'($urandom));
      step(1, 0, 0, AW'(20 + i), '0, '0);
    end
    step(1, 0, 0, 8'd21, '0, '0);
    step(1, 0, 0, 8'd22, '0, '0);
    step(1, 1, 0, 8'd21, 2'b11, W'($urandom));
    step(1, 1, 0, 8'd22, 2'b11, W'($urandom));
    step(1, 0, 0, 8'd22, '0, '0);
    step(1, 0, 0, 8'd21, '0, '0);
    cur_tag = "R8";
    step(1, 1, 0, 8'd40, 2'b01, 18'h15A5A);
    step(1, 1, 0, 8'd40, 2'b10, 18'h2C3C3);
    step(1, 1, 0, 8'd40, 2'b00, 18'h3FFFF);
    step(1, 0, 0, 8'd40, '0, '0);
    cur_tag = "R4";
    d = W'($urandom);
    step(1, 1, 0, 8'd50, 2'b11, d);
    repeat (3) nop();
    step(1, 0, 0, 8'd50, '0, '0);
    cur_tag = "R9";
    step(0, 1, 0, 8'd60, 2'b11, W'($urandom));
    step(0, 0, 0, 8'd60, '0, '0);
    step(1, 0, 0, 8'd60, '0, '0);
    cur_tag = "R11";
    step(1, 0, 0, 8'd66, '0, '0);
    for (int i = 0; i < 5; i++) step(0, 1, 1, 8'd200, 2'b11, W'($urandom));
    step(1, 1, 0, 8'd73, 2'b11, W'($urandom));
    for (int i = 0; i < 3; i++) step(1, 0, 1, 8'd9, 2'b11, W'($urandom));
    step(1, 0, 0, 8'd72, '0, '0);
    step(1, 0, 1, 8'd73, '0, '0);
    nop();
    step(1, 0, 1, 8'd74, '0, '0);
    nop();
    cur_tag = "R13";
    step(1, 1, 0, 8'd70, 2'b11, W'($urandom));
    sleep = 1'b1;
    step(1, 1, 0, 8'd70, 2'b11, W'($urandom));
    step(1, 0, 0, 8'd70, '0, '0);
    step(1, 0, 1, 8'd70, '0, '0);
    sleep = 1'b0;
    step(1, 0, 1, 8'd70, '0, '0);
    step(1, 0, 0, 8'd70, '0, '0);
    nop();
    cur_tag = "R10";
    oe_probe = 1;
    step(1, 0, 0, 8'd70, '0, '0);
    step(1, 0, 0, 8'd40, '0, '0);
    nop();
    oe_probe = 0;
    oe = 1'b0;
    step(1, 0, 0, 8'd21, '0, '0);
    nop();
    oe = 1'b1;
    cur_tag = "";
  endtask

  task automatic random_run(int n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      sleep = ($urandom_range(0, 99) < 4);
      oe = ($urandom_range(0, 9) != 0);
      a = ($urandom_range(0, 7) == 0) ? AW'($urandom) : AW'($urandom_range(0, 15));
      step($urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
           a, NB'($urandom), W'($urandom));
    end
    sleep = 1'b0;
    oe = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < 4; s++) begin
      reset_dut(s[0], s[1]);
      for (int i = 0; i < WORDS; i++) step(1, 1, 0, AW'(i), 2'b11, W'($urandom));
      nop(); nop();
      directed();
      random_run(1200);
      nop(); nop();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule